// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Selector

This block decides, for every processor in a cluster, which pending interrupt deserves its attention. Each interrupt ID carries a per-CPU enable bit, a per-CPU pending bit, an 8-bit priority and, for shared IDs, a mask of the CPUs it may be delivered to. The block walks all IDs in a repeating sweep, one ID per clock, and keeps a running best candidate for every CPU in parallel. When a sweep ends it publishes, per CPU, the ID of the most urgent candidate and a request line. A numerically smaller priority is more urgent.

Two thresholds stand between the winner and the processor. The priority mask alone decides whether the winner's ID is reported; otherwise the reported ID is 1023, the spurious value. The request line also requires the winner to beat the CPU's running priority, which is 0x100 while the CPU is idle. A distributor-wide enable and a per-CPU enable gate everything. Priorities of the private IDs 0..31 are held per CPU; IDs from 32 upward share one priority and have a target mask. Priority and target values live in on-chip memories loaded through two simple write ports; enable, pending, masks and running priorities come in as plain vectors.

Top module: `pend_arbiter`

## Requirements
- R1: Among the candidates of a CPU, the one with the smallest priority value is chosen.
- R2: When several candidates share the smallest priority value, the lowest ID is chosen.
- R3: An ID is a candidate for CPU c only if bit c*NID+id is set in both the enable vector and the pending vector.
- R4: An ID of 32 or above is a candidate for CPU c only if bit c of its target mask is set; IDs 0..31 ignore the target mask.
- R5: While the distributor enable is low, every request line is low and every reported ID is 1023.
- R6: While the enable of CPU c is low, that CPU's request line is low and its reported ID is 1023; other CPUs are not affected.
- R7: The reported ID of a CPU is the winner's ID when the winner's priority is strictly below that CPU's 8-bit priority mask, and 1023 otherwise.
- R8: The request line of a CPU is high only when the winner's priority is strictly below both the priority mask and the 9-bit running priority (0x100 means idle).
- R9: With no candidate, the reported ID is 1023 and the request line is low, whatever the mask.
- R10: Priority writes to an ID below 32 affect only the addressed CPU's copy; writes to an ID of 32 or above affect all CPUs, and the CPU field is ignored.
- R11: After reset the request lines are low and reported IDs are 1023; outputs change only once per sweep and reflect any input or memory change within 2*NID+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Distributor-wide enable |
| cpu_en_i | input | NCPU | Per-CPU enable, bit c for CPU c |
| en_i | input | NCPU*NID | Enable bits, bit c*NID+id |
| pend_i | input | NCPU*NID | Pending bits, bit c*NID+id |
| pmask_i | input | NCPU*8 | Priority mask of CPU c in bits c*8+:8 |
| rpr_i | input | NCPU*9 | Running priority of CPU c in bits c*9+:9 |
| prio_we_i | input | 1 | Priority memory write strobe |
| prio_id_i | input | 10 | ID whose priority is written |
| prio_cpu_i | input | CPUW | CPU copy written, used for IDs below 32 |
| prio_val_i | input | 8 | Priority value written |
| tgt_we_i | input | 1 | Target memory write strobe |
| tgt_id_i | input | 10 | ID whose target mask is written |
| tgt_val_i | input | NCPU | Target mask, bit c allows CPU c |
| irq_o | output | NCPU | Request line per CPU |
| hppid_o | output | NCPU*10 | Reported highest pending ID of CPU c in bits c*10+:10 |

## Verification
On every cycle the assertions check that the outputs only move right after a sweep closes, that a raised request line always comes with a real in-range ID, that a reported ID is either valid or spurious, and that a low distributor or CPU enable at the end of a sweep forces the idle outputs. The choice itself (priority ordering, lowest-ID tie break, target filtering, per-CPU private priorities and the two threshold comparisons) can only be shown by the bench's scenarios, which compare both CPUs against an arithmetic model after directed cases and a long pseudo-random sweep.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W   = 8;
  localparam int RPR_W    = PRIO_W + 1;
  localparam int ID_W     = 10;
  localparam int PRIV_IDS = 32;
  localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
  localparam logic [RPR_W-1:0] NO_PRIO     = 9'h100;
endpackage

// File: rtl/arb_scan_ctrl.sv
module arb_scan_ctrl
  import arb_pkg::*;
#(
  parameter int NID = 64
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ID_W-1:0] idx_o,
  output logic            first_o,
  output logic            last_o
);
  localparam logic [ID_W-1:0] LAST_IDX = ID_W'(NID - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
    end else if (idx_o == LAST_IDX) begin
      idx_o <= '0;
    end else begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign first_o = (idx_o == '0);
  assign last_o  = (idx_o == LAST_IDX);
endmodule

// File: rtl/arb_prio_store.sv
module arb_prio_store
  import arb_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NID  = 64,
  parameter int CPUW = 1
) (
  input  logic                   clk,
  input  logic                   prio_we,
  input  logic [ID_W-1:0]        prio_id,
  input  logic [CPUW-1:0]        prio_cpu,
  input  logic [PRIO_W-1:0]      prio_val,
  input  logic                   tgt_we,
  input  logic [ID_W-1:0]        tgt_id,
  input  logic [NCPU-1:0]        tgt_val,
  input  logic [ID_W-1:0]        rd_idx,
  output logic [NCPU*PRIO_W-1:0] priv_q,
  output logic [PRIO_W-1:0]      shr_q,
  output logic [NCPU-1:0]        tgt_q
);
  localparam int SHD = (NID > PRIV_IDS) ? NID - PRIV_IDS : 1;
  localparam int SAW = (SHD > 1) ? $clog2(SHD) : 1;
  localparam int IXW = $clog2(NID);
  localparam logic [ID_W-1:0] PRIV_LIM = ID_W'(PRIV_IDS);
  localparam logic [ID_W-1:0] ID_LIM   = ID_W'(NID);

  logic wr_is_priv, rd_is_priv;
  logic [SAW-1:0] wr_sa, rd_sa;

  assign wr_is_priv = (prio_id < PRIV_LIM);
  assign rd_is_priv = (rd_idx < PRIV_LIM);
  assign wr_sa = SAW'(prio_id - PRIV_LIM);
  assign rd_sa = rd_is_priv ? '0 : SAW'(rd_idx - PRIV_LIM);

  // Private priorities: one small memory per CPU, written only for that CPU
  for (genvar c = 0; c < NCPU; c++) begin : g_priv
    logic [PRIO_W-1:0] pmem [PRIV_IDS];
    always_ff @(posedge clk) begin
      if (prio_we && wr_is_priv && (prio_cpu == CPUW'(c))) begin
        pmem[prio_id[4:0]] <= prio_val;
      end
      priv_q[c*PRIO_W +: PRIO_W] <= pmem[rd_idx[4:0]];
    end
  end

  // Shared priorities of IDs 32 and above
  logic [PRIO_W-1:0] smem [SHD];
  always_ff @(posedge clk) begin
    if (prio_we && !wr_is_priv && (prio_id < ID_LIM)) begin
      smem[wr_sa] <= prio_val;
    end
    shr_q <= smem[rd_sa];
  end

  // Target masks
  logic [NCPU-1:0] tmem [NID];
  always_ff @(posedge clk) begin
    if (tgt_we && (tgt_id < ID_LIM)) begin
      tmem[tgt_id[IXW-1:0]] <= tgt_val;
    end
    tgt_q <= tmem[rd_idx[IXW-1:0]];
  end
endmodule

// File: rtl/arb_cpu_select.sv
module arb_cpu_select
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              first,
  input  logic              last,
  input  logic [ID_W-1:0]   idx,
  input  logic              cand,
  input  logic [PRIO_W-1:0] prio,
  input  logic              glb_en,
  input  logic              cpu_en,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [RPR_W-1:0]  rpr,
  output logic              irq,
  output logic [ID_W-1:0]   hppid
);
  logic [RPR_W-1:0] best_p, base_p, nxt_p;
  logic [ID_W-1:0]  best_id, base_id, nxt_id;
  logic             take, pass;

  always_comb begin
    base_p  = first ? NO_PRIO : best_p;
    base_id = first ? SPURIOUS_ID : best_id;
    // strict compare: an equal priority seen later never displaces the earlier ID
    take    = cand && ({1'b0, prio} < base_p);
    nxt_p   = take ? {1'b0, prio} : base_p;
    nxt_id  = take ? idx : base_id;
    pass    = glb_en && cpu_en && (nxt_p < {1'b0, pmask});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_p  <= NO_PRIO;
      best_id <= SPURIOUS_ID;
      irq     <= 1'b0;
      hppid   <= SPURIOUS_ID;
    end else begin
      best_p  <= nxt_p;
      best_id <= nxt_id;
      if (last) begin
        hppid <= pass ? nxt_id : SPURIOUS_ID;
        irq   <= pass && (nxt_p < rpr);
      end
    end
  end
endmodule

// File: rtl/pend_arbiter.sv
module pend_arbiter
  import arb_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NID  = 64,
  localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   glb_en_i,
  input  logic [NCPU-1:0]        cpu_en_i,
  input  logic [NCPU*NID-1:0]    en_i,
  input  logic [NCPU*NID-1:0]    pend_i,
  input  logic [NCPU*PRIO_W-1:0] pmask_i,
  input  logic [NCPU*RPR_W-1:0]  rpr_i,
  input  logic                   prio_we_i,
  input  logic [ID_W-1:0]        prio_id_i,
  input  logic [CPUW-1:0]        prio_cpu_i,
  input  logic [PRIO_W-1:0]      prio_val_i,
  input  logic                   tgt_we_i,
  input  logic [ID_W-1:0]        tgt_id_i,
  input  logic [NCPU-1:0]        tgt_val_i,
  output logic [NCPU-1:0]        irq_o,
  output logic [NCPU*ID_W-1:0]   hppid_o
);
  localparam int IXW = $clog2(NID);

  logic [ID_W-1:0] idx, idx_q;
  logic            first, last, first_q, last_q;
  logic [NCPU*PRIO_W-1:0] priv_q;
  logic [PRIO_W-1:0]      shr_q;
  logic [NCPU-1:0]        tgt_q;
  logic                   is_priv_q;

  arb_scan_ctrl #(.NID(NID)) scan_i (
    .clk(clk), .rst(rst), .idx_o(idx), .first_o(first), .last_o(last)
  );

  arb_prio_store #(.NCPU(NCPU), .NID(NID), .CPUW(CPUW)) store_i (
    .clk(clk), .prio_we(prio_we_i), .prio_id(prio_id_i), .prio_cpu(prio_cpu_i),
    .prio_val(prio_val_i), .tgt_we(tgt_we_i), .tgt_id(tgt_id_i),
    .tgt_val(tgt_val_i), .rd_idx(idx), .priv_q(priv_q), .shr_q(shr_q),
    .tgt_q(tgt_q)
  );

  // Stage register aligning the scan index with the memory read data
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      idx_q   <= idx;
      first_q <= first;
      last_q  <= last;
    end
  end

  assign is_priv_q = (idx_q < ID_W'(PRIV_IDS));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NID-1:0]    en_row, pend_row;
    logic              cand;
    logic [PRIO_W-1:0] prio;

    assign en_row   = en_i[c*NID +: NID];
    assign pend_row = pend_i[c*NID +: NID];
    assign cand = en_row[idx_q[IXW-1:0]] && pend_row[idx_q[IXW-1:0]] &&
                  (is_priv_q || tgt_q[c]);
    assign prio = is_priv_q ? priv_q[c*PRIO_W +: PRIO_W] : shr_q;

    arb_cpu_select sel_i (
      .clk(clk), .rst(rst), .first(first_q), .last(last_q), .idx(idx_q),
      .cand(cand), .prio(prio), .glb_en(glb_en_i), .cpu_en(cpu_en_i[c]),
      .pmask(pmask_i[c*PRIO_W +: PRIO_W]), .rpr(rpr_i[c*RPR_W +: RPR_W]),
      .irq(irq_o[c]), .hppid(hppid_o[c*ID_W +: ID_W])
    );
  end
endmodule

// File: rtl/pend_arbiter_chk.sv
module pend_arbiter_chk
  import arb_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NID  = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sweep_end,
  input logic                 glb_en_i,
  input logic [NCPU-1:0]      cpu_en_i,
  input logic [NCPU-1:0]      irq_o,
  input logic [NCPU*ID_W-1:0] hppid_o
);
  localparam logic [ID_W-1:0] ID_LIM = ID_W'(NID);

  // R11: outputs only move in the cycle after a sweep closes
  a_r11_update_at_sweep_end: assert property (@(posedge clk) disable iff (rst)
    !$past(sweep_end) |-> ($stable(irq_o) && $stable(hppid_o)));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    logic [ID_W-1:0] id_c;
    assign id_c = hppid_o[c*ID_W +: ID_W];

    // R8: a raised request always carries a real winner
    a_r8_irq_has_id: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> (id_c < ID_LIM));

    // R7: the reported ID is either in range or spurious
    a_r7_id_range: assert property (@(posedge clk) disable iff (rst)
      (id_c == SPURIOUS_ID) || (id_c < ID_LIM));

    // R5: distributor disabled at sweep end forces idle outputs
    a_r5_global_off: assert property (@(posedge clk) disable iff (rst)
      (sweep_end && !glb_en_i) |=> (!irq_o[c] && (id_c == SPURIOUS_ID)));

    // R6: CPU disabled at sweep end forces idle outputs for that CPU
    a_r6_cpu_off: assert property (@(posedge clk) disable iff (rst)
      (sweep_end && !cpu_en_i[c]) |=> (!irq_o[c] && (id_c == SPURIOUS_ID)));
  end
endmodule

bind pend_arbiter pend_arbiter_chk #(.NCPU(NCPU), .NID(NID)) chk_i (
  .clk(clk), .rst(rst), .sweep_end(last_q), .glb_en_i(glb_en_i),
  .cpu_en_i(cpu_en_i), .irq_o(irq_o), .hppid_o(hppid_o)
);

// File: tb/pend_arbiter_tb_top.sv
module pend_arbiter_tb_top;
  localparam int NCPU = 2;
  localparam int NID  = 64;
  localparam int SETTLE = 2 * NID + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             glb_en;
  logic [1:0]       cpu_en;
  logic [127:0]     en_v, pend_v;
  logic [15:0]      pmask_v;
  logic [17:0]      rpr_v;
  logic             prio_we, tgt_we;
  logic [9:0]       prio_id, tgt_id;
  logic [0:0]       prio_cpu;
  logic [7:0]       prio_val;
  logic [1:0]       tgt_val;
  logic [1:0]       irq;
  logic [19:0]      hppid;

  logic [7:0] m_priv [2][32];
  logic [7:0] m_sh [32];
  logic [1:0] m_tgt [64];

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1bad_c0de;

  pend_arbiter #(.NCPU(NCPU), .NID(NID)) dut_i (
    .clk(clk), .rst(rst), .glb_en_i(glb_en), .cpu_en_i(cpu_en),
    .en_i(en_v), .pend_i(pend_v), .pmask_i(pmask_v), .rpr_i(rpr_v),
    .prio_we_i(prio_we), .prio_id_i(prio_id), .prio_cpu_i(prio_cpu),
    .prio_val_i(prio_val), .tgt_we_i(tgt_we), .tgt_id_i(tgt_id),
    .tgt_val_i(tgt_val), .irq_o(irq), .hppid_o(hppid)
  );

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // Arithmetic reference of one CPU's outputs
  task automatic model(input int c, output logic e_irq, output logic [9:0] e_id);
    int best_p = 256;
    int best_i = 1023;
    for (int id = 0; id < NID; id++) begin
      int p;
      logic ok;
      ok = en_v[c*NID+id] && pend_v[c*NID+id] && (id < 32 || m_tgt[id][c]);
      p = (id < 32) ? int'(m_priv[c][id]) : int'(m_sh[id-32]);
      if (ok && p < best_p) begin
        best_p = p;
        best_i = id;
      end
    end
    if (glb_en && cpu_en[c] && best_p < int'(pmask_v[c*8 +: 8])) begin
      e_id  = 10'(best_i);
      e_irq = (best_p < int'(rpr_v[c*9 +: 9]));
    end else begin
      e_id  = 10'd1023;
      e_irq = 1'b0;
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCPU; c++) begin
      logic ei;
      logic [9:0] eid;
      model(c, ei, eid);
      checks++;
      if (irq[c] !== ei || hppid[c*10 +: 10] !== eid) begin
        errors++;
        $display("FAIL %s cpu%0d actual irq=%0b id=%0d expected irq=%0b id=%0d",
                 tag, c, irq[c], hppid[c*10 +: 10], ei, eid);
      end
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    #1;
  endtask

  task automatic wprio(input int id, input int c, input logic [7:0] v);
    @(negedge clk);
    prio_we = 1'b1; prio_id = 10'(id); prio_cpu = 1'(c); prio_val = v;
    if (id < 32) m_priv[c][id] = v;
    else m_sh[id-32] = v;
  endtask

  task automatic wtgt(input int id, input logic [1:0] v);
    @(negedge clk);
    tgt_we = 1'b1; tgt_id = 10'(id); tgt_val = v;
    m_tgt[id] = v;
  endtask

  task automatic wdone();
    @(negedge clk);
    prio_we = 1'b0; tgt_we = 1'b0;
  endtask

  task automatic setbit(input int c, input int id, input logic e, input logic p);
    en_v[c*NID+id] = e;
    pend_v[c*NID+id] = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    glb_en = 1'b1; cpu_en = 2'b11; en_v = '0; pend_v = '0;
    pmask_v = 16'hffff; rpr_v = {9'h100, 9'h100};
    prio_we = 1'b0; tgt_we = 1'b0; prio_id = '0; tgt_id = '0;
    prio_cpu = '0; prio_val = '0; tgt_val = '0;
    repeat (4) @(posedge clk);
    #1;
    // R11: reset state
    check_all("R11 reset");
    @(negedge clk);
    rst = 1'b0;

    for (int id = 0; id < 32; id++) begin
      wprio(id, 0, 8'ha0);
      wprio(id, 1, 8'ha0);
    end
    for (int id = 32; id < NID; id++) wprio(id, 0, 8'ha0);
    for (int id = 0; id < NID; id++) wtgt(id, 2'b00);
    wdone();
    settle();
    check_all("R9 no candidates");

    // R1: smaller value wins, shared IDs routed to cpu0 only (R4)
    wprio(40, 1, 8'h30); wprio(50, 0, 8'h20);
    wtgt(40, 2'b01); wtgt(50, 2'b01);
    wdone();
    setbit(0, 40, 1, 1); setbit(0, 50, 1, 1);
    setbit(1, 40, 1, 1); setbit(1, 50, 1, 1);
    settle();
    check_all("R1 R4 lowest value");

    // R2: equal priority, lowest ID wins
    wprio(40, 0, 8'h20); wdone();
    settle();
    check_all("R2 tie");

    // R4: private ID ignores target; R10: per-CPU private copies
    wprio(5, 0, 8'h10); wprio(5, 1, 8'h90); wdone();
    setbit(0, 5, 1, 1); setbit(1, 5, 1, 1);
    settle();
    check_all("R4 R10 private");
    wtgt(40, 2'b11); wdone();
    settle();
    check_all("R10 shared vs private");

    // R3: enable without pending, pending without enable
    setbit(0, 5, 1, 0); setbit(1, 40, 0, 1);
    settle();
    check_all("R3 enable and pending");

    // R7: mask equal to winner blocks, one above passes
    pmask_v[7:0] = 8'h20;
    settle();
    check_all("R7 mask equal");
    pmask_v[7:0] = 8'h21;
    settle();
    check_all("R7 mask above");

    // R8: running priority equal blocks the line but not the ID
    rpr_v[8:0] = 9'h020;
    settle();
    check_all("R8 running equal");
    rpr_v[8:0] = 9'h021;
    settle();
    check_all("R8 running above");
    rpr_v[8:0] = 9'h100;

    // R5 / R6
    glb_en = 1'b0;
    settle();
    check_all("R5 global off");
    glb_en = 1'b1;
    cpu_en = 2'b10;
    settle();
    check_all("R6 cpu off");
    cpu_en = 2'b11;

    // Pseudo-random sweep over all functions
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] r;
        r = rnd();
        wprio(int'(r[5:0]), int'(r[6]), (r[20]) ? 8'(r[15:8] & 8'h0f) : r[15:8]);
        wtgt(int'(r[29:24]), r[31:30]);
      end
      wdone();
      en_v   = {rnd(), rnd(), rnd(), rnd()} | {rnd(), rnd(), rnd(), rnd()};
      pend_v = {rnd(), rnd(), rnd(), rnd()} & {rnd(), rnd(), rnd(), rnd()};
      if (it % 5 == 0) pend_v = '0;
      pmask_v = (it % 3 == 0) ? 16'hffff : 16'(rnd());
      rpr_v   = (it % 4 == 0) ? {9'h100, 9'h100} : 18'(rnd());
      glb_en  = (it % 11 != 7);
      cpu_en  = (it % 7 == 3) ? 2'(rnd()) : 2'b11;
      settle();
      check_all("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule